// File: doc/BRIEF.md
# Reference Clock Loss Detector

This block watches a set of reference clock inputs and raises one alarm bit per input when that reference stops toggling. It has no timer of its own. It measures time in edges of the phase detector feedback clock, and that clock is shared by all channels. A fast free-running system clock samples the raw reference and feedback clocks, so both reach the logic through synchronizers. Edges are then found by comparing successive synchronized samples. A rising transition and a falling transition each count as one edge.

Each feedback edge closes an observation interval. An interval that saw at least one reference edge counts as active; how many edges it saw does not matter. The alarm for a channel goes high once three intervals in a row have been empty. It goes low again at the first feedback edge that closes an active interval. The default build has two channels, and they share nothing except the feedback synchronizer.

Top module: `ref_activity_monitor`

## Requirements
- R1: While the synchronous reset `rst` is high, and after it is released, every alarm bit is low until a channel has seen three empty feedback intervals.
- R2: The rising and the falling transition of the feedback clock each close one interval. Three single feedback transitions with no reference activity are enough to raise the alarm.
- R3: A single reference transition in either direction, rising or falling, makes its interval active.
- R4: For each channel, `lossAlarm` goes high after exactly three consecutive feedback edges with no reference edge in between. It goes high on the third rising edge of `clk` counted from the first edge that samples the raw feedback transition closing the third empty interval. After two such edges it is still low.
- R5: While the reference stays silent and the feedback clock keeps running, the alarm stays high. The internal count saturates and does not wrap.
- R6: The alarm drops at the first feedback edge that closes an interval containing reference activity.
- R7: Any number of reference edges in one interval counts only as activity. A reference that toggles on every system clock never raises the alarm.
- R8: Without feedback edges the state does not change. The alarm neither rises nor falls, whatever the reference does.
- R9: Each channel has its own monitor and its own bit of `lossAlarm`. A silent reference on one channel does not affect the others.
- R10: A reference edge detected in the same system cycle as a feedback edge counts toward the interval that this feedback edge closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples both raw clocks |
| rst | input | 1 | Synchronous reset, active high |
| refClkRaw | input | NUM_REFS | Raw reference clocks, one per channel, asynchronous to `clk` |
| fbClkRaw | input | 1 | Raw phase detector feedback clock, asynchronous to `clk` |
| lossAlarm | output | NUM_REFS | Registered loss alarm, one bit per channel, high = reference absent |

## Verification
The only visible state is the alarm bit, so the fault classes show up differently. A wrong miss count or a lost activity flag shows up as an alarm that rises one feedback edge too early or too late. A count that wraps shows up as an alarm that drops while the reference is still silent. Both become visible within a few feedback intervals. A flag that is not cleared shows up as an alarm that never rises once the reference stops. Edge counting, meaning single transitions in each direction and reference edges that coincide with feedback edges, is exposed by driving one transition at a time and checking the alarm at the exact cycle given by the three-register latency. A behavioural model in the bench runs in parallel with the design and is compared with the alarm bits on every system clock. Any difference is therefore caught in the cycle where it first appears.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  // Strobes the per-channel control hands to its datapath each cycle.
  typedef struct packed {
    logic setSeen;   // reference edge seen, no feedback edge this cycle
    logic clrSeen;   // feedback edge: interval closed, restart observation
    logic clrMiss;   // closed interval was active
    logic incMiss;   // closed interval was empty and count not yet at limit
  } missStrobes_t;

endpackage

// File: rtl/refmon_sync_edge.sv
module refmon_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic edgeOut
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] syncChain;
  logic              lastLevel;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= rawIn;
      end
    end else begin : gChain
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= {syncChain[STAGES-2:0], rawIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lastLevel <= 1'b0;
    else     lastLevel <= syncChain[TOP];
  end

  // Either direction of change is one edge.
  assign edgeOut = syncChain[TOP] ^ lastLevel;

endmodule

// File: rtl/refmon_ctrl.sv
module refmon_ctrl
  import refmon_pkg::*;
(
  input  logic         fbEdge,
  input  logic         refEdge,
  input  logic         seenFlag,
  input  logic         missSat,
  output missStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    if (fbEdge) begin
      strobes.clrSeen = 1'b1;
      // A reference edge in the closing cycle belongs to this interval.
      if (seenFlag || refEdge) strobes.clrMiss = 1'b1;
      else if (!missSat)       strobes.incMiss = 1'b1;
    end else if (refEdge) begin
      strobes.setSeen = 1'b1;
    end
  end

endmodule

// File: rtl/refmon_dpath.sv
module refmon_dpath
  import refmon_pkg::*;
#(
  parameter int MISS_LIMIT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  missStrobes_t strobes,
  input  logic         fbEdge,
  input  logic         refEdge,
  output logic         seenFlag,
  output logic         missSat,
  output logic         alarm
);

  localparam int CW = $clog2(MISS_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_V     = CW'(MISS_LIMIT);
  localparam logic [CW-1:0] LIMIT_PRE_V = CW'(MISS_LIMIT - 1);

  logic [CW-1:0] missCnt;
  logic [CW-1:0] missNext;

  always_comb begin
    missNext = missCnt;
    if (strobes.clrMiss)      missNext = '0;
    else if (strobes.incMiss) missNext = missCnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      missCnt  <= '0;
      seenFlag <= 1'b0;
      alarm    <= 1'b0;
    end else begin
      missCnt <= missNext;
      alarm   <= (missNext == LIMIT_V);
      if (strobes.clrSeen)      seenFlag <= 1'b0;
      else if (strobes.setSeen) seenFlag <= 1'b1;
    end
  end

  assign missSat = (missCnt == LIMIT_V);

  AST_ALARM_FROZEN_NO_FB: assert property (@(posedge clk) disable iff (rst)
    !fbEdge |=> (alarm == $past(alarm)))
    else $error("alarm moved without a feedback edge"); // R8

  AST_ALARM_RAISE: assert property (@(posedge clk) disable iff (rst)
    (fbEdge && !seenFlag && !refEdge && missCnt == LIMIT_PRE_V) |=> alarm)
    else $error("alarm missing after empty intervals"); // R4

  AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fbEdge && !seenFlag && !refEdge && alarm) |=> alarm)
    else $error("alarm dropped while reference silent"); // R5

  AST_ALARM_DROP: assert property (@(posedge clk) disable iff (rst)
    (fbEdge && seenFlag) |=> !alarm)
    else $error("alarm kept after active interval"); // R6

  AST_COINCIDENT_COUNTS: assert property (@(posedge clk) disable iff (rst)
    (fbEdge && refEdge) |=> (!alarm && !seenFlag))
    else $error("coincident reference edge not credited"); // R10

  AST_SEEN_SETS: assert property (@(posedge clk) disable iff (rst)
    (refEdge && !fbEdge) |=> seenFlag)
    else $error("reference edge not recorded"); // R3

endmodule

// File: rtl/ref_activity_monitor.sv
module ref_activity_monitor
  import refmon_pkg::*;
#(
  parameter int NUM_REFS    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MISS_LIMIT  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REFS-1:0] refClkRaw,
  input  logic                fbClkRaw,
  output logic [NUM_REFS-1:0] lossAlarm
);

  logic fbEdge;

  // One feedback synchronizer serves every channel.
  refmon_sync_edge #(.STAGES(SYNC_STAGES)) fbSync_i (
    .clk    (clk),
    .rst    (rst),
    .rawIn  (fbClkRaw),
    .edgeOut(fbEdge)
  );

  generate
    for (genvar ch = 0; ch < NUM_REFS; ch++) begin : gChan
      logic         refEdge;
      logic         seenFlag;
      logic         missSat;
      missStrobes_t strobes;

      refmon_sync_edge #(.STAGES(SYNC_STAGES)) refSync_i (
        .clk    (clk),
        .rst    (rst),
        .rawIn  (refClkRaw[ch]),
        .edgeOut(refEdge)
      );

      refmon_ctrl ctrl_i (
        .fbEdge  (fbEdge),
        .refEdge (refEdge),
        .seenFlag(seenFlag),
        .missSat (missSat),
        .strobes (strobes)
      );

      refmon_dpath #(.MISS_LIMIT(MISS_LIMIT)) dpath_i (
        .clk     (clk),
        .rst     (rst),
        .strobes (strobes),
        .fbEdge  (fbEdge),
        .refEdge (refEdge),
        .seenFlag(seenFlag),
        .missSat (missSat),
        .alarm   (lossAlarm[ch])
      );
    end
  endgenerate

endmodule

// File: tb/ref_activity_monitor_tb_top.sv
module ref_activity_monitor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 2;
  localparam int LIMIT      = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] refRaw = '0;
  logic           fbRaw = 1'b0;
  logic [NCH-1:0] alarmOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_activity_monitor #(.NUM_REFS(NCH), .SYNC_STAGES(2), .MISS_LIMIT(LIMIT)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .refClkRaw(refRaw),
    .fbClkRaw (fbRaw),
    .lossAlarm(alarmOut)
  );

  int total = 0;
  int bad = 0;
  string phase = "R1";

  // Stimulus rate generators (half period in system cycles, 0 = stopped).
  int fbHalf = 0;
  int fbCnt = 0;
  int refHalf [NCH];
  int refCnt [NCH];

  // Behavioural model: raw sample history per clock, interval state per channel.
  logic [2:0] mFbH;
  logic [2:0] mRefH [NCH];
  bit         mSeen [NCH];
  int         mMiss [NCH];
  bit         mAlarm [NCH];

  always @(posedge clk) begin : modelUpd
    bit fbE;
    bit rE;
    if (rst) begin
      mFbH = '0;
      for (int c = 0; c < NCH; c++) begin
        mRefH[c] = '0; mSeen[c] = 0; mMiss[c] = 0; mAlarm[c] = 0;
      end
    end else begin
      // A raw change sampled two edges ago is the edge acted on now.
      fbE = (mFbH[1] != mFbH[2]);
      for (int c = 0; c < NCH; c++) begin
        rE = (mRefH[c][1] != mRefH[c][2]);
        if (fbE) begin
          if (mSeen[c] || rE) mMiss[c] = 0;
          else if (mMiss[c] < LIMIT) mMiss[c] = mMiss[c] + 1;
          mSeen[c] = 0;
        end else if (rE) begin
          mSeen[c] = 1;
        end
        mAlarm[c] = (mMiss[c] == LIMIT);
        mRefH[c] = {mRefH[c][1:0], refRaw[c]};
      end
      mFbH = {mFbH[1:0], fbRaw};
    end
  end

  function automatic logic [NCH-1:0] modelVec();
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = mAlarm[c];
    return v;
  endfunction

  task automatic checkVal(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: alarm=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setFb(int h);
    fbHalf = h; fbCnt = 0;
  endtask

  task automatic setRef(int c, int h);
    refHalf[c] = h; refCnt[c] = 0;
  endtask

  // One cycle: compare with the model away from the edge, then drive.
  task automatic stepCycle();
    @(negedge clk);
    checkVal(phase, alarmOut, modelVec());
    if (fbHalf > 0) begin
      fbCnt++;
      if (fbCnt >= fbHalf) begin fbRaw = ~fbRaw; fbCnt = 0; end
    end
    for (int c = 0; c < NCH; c++) begin
      if (refHalf[c] > 0) begin
        refCnt[c]++;
        if (refCnt[c] >= refHalf[c]) begin refRaw[c] = ~refRaw[c]; refCnt[c] = 0; end
      end
    end
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) stepCycle();
  endtask

  task automatic toggleFb();
    @(negedge clk);
    checkVal(phase, alarmOut, modelVec());
    fbRaw = ~fbRaw;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    for (int c = 0; c < NCH; c++) begin refHalf[c] = 0; refCnt[c] = 0; end

    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      checkVal("R1 reset", alarmOut, '0);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1: active references after reset, no alarm
    phase = "R1";
    setFb(5); setRef(0, 2); setRef(1, 3);
    runCycles(100);
    checkVal("R1 active", alarmOut, 2'b00);

    // R4 and R9: channel 0 goes silent, channel 1 keeps running
    phase = "R4 R9";
    setRef(0, 0);
    runCycles(60);
    checkVal("R9 independent", alarmOut, 2'b01);

    // R5: alarm held while silence continues
    phase = "R5";
    runCycles(100);
    checkVal("R5 saturate", alarmOut, 2'b01);

    // R6: activity resumes
    phase = "R6";
    setRef(0, 4);
    runCycles(40);
    checkVal("R6 drop", alarmOut, 2'b00);

    // R7: very fast reference, slow feedback
    phase = "R7";
    setFb(20); setRef(0, 1); setRef(1, 1);
    runCycles(200);
    checkVal("R7 fast ref", alarmOut, 2'b00);

    // R3: single reference transitions of either direction
    phase = "R3";
    setFb(6); setRef(0, 0); setRef(1, 0);
    runCycles(60);
    checkVal("R3 silent", alarmOut, 2'b11);
    @(negedge clk); refRaw[0] = ~refRaw[0];
    runCycles(12);
    checkVal("R3 first dir", alarmOut, 2'b10);
    runCycles(40);
    checkVal("R3 silent again", alarmOut, 2'b11);
    @(negedge clk); refRaw[0] = ~refRaw[0];
    runCycles(12);
    checkVal("R3 second dir", alarmOut, 2'b10);

    // R2: feedback transitions one at a time
    phase = "R2";
    setFb(0);
    runCycles(10);
    @(negedge clk); refRaw = ~refRaw;
    runCycles(6);
    toggleFb();
    runCycles(8);
    checkVal("R2 active interval", alarmOut, 2'b00);
    toggleFb(); runCycles(6);
    toggleFb(); runCycles(6);
    checkVal("R2 two empty", alarmOut, 2'b00);
    toggleFb();
    runCycles(1);
    checkVal("R4 not before latency", alarmOut, 2'b00);
    runCycles(3);
    checkVal("R2 third empty", alarmOut, 2'b11);

    // R8: no feedback, state frozen
    phase = "R8";
    runCycles(300);
    checkVal("R8 frozen high", alarmOut, 2'b11);
    setRef(0, 2); setRef(1, 5);
    runCycles(30);
    checkVal("R8 ref without fb", alarmOut, 2'b11);
    setRef(0, 0); setRef(1, 0);
    toggleFb();
    runCycles(5);
    checkVal("R8 released by fb", alarmOut, 2'b00);

    // R10: reference edges only in the same cycle as feedback edges
    phase = "R10";
    setFb(8); setRef(0, 8); setRef(1, 8);
    runCycles(200);
    checkVal("R10 coincident", alarmOut, 2'b00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule